// File: doc/BRIEF.md
# Display Register Window Bridge

This block sits between a memory-mapped bus slave port and the register logic of a display controller. One memory window carries three sub-windows. The legacy sub-window reaches an 8-bit I/O-style register file whose port numbers start at 0x3C0. The mode sub-window reaches a 16-bit register file that has an index port and a data port. The extended sub-window holds two 32-bit words: a read-only size word and a framebuffer byte-order flag that the bridge keeps itself.

A bus access is taken with a valid/ready handshake. The bridge first decodes which sub-window is addressed and checks that the access size is allowed there. Legacy accesses are then broken into a run of byte operations, one per cycle, in ascending port order. Mode accesses are broken into 16-bit units, and each unit is an index write followed by a data transfer. Read bytes are gathered into a little-endian word. The bridge returns a single response pulse and only then accepts the next access.

Sizes are coded on `req_size` as 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for illegal. With the default parameters the legacy sub-window is 0x400 to 0x41F, the mode sub-window is 0x500 to 0x517 and the extended sub-window is 0x600 to 0x607.

Top module: `mmio_display_bridge`

## Requirements
- R1: An access at legacy offset A of 1, 2 or 4 bytes drives one byte operation per cycle on `leg_port`. The operations address ports 0x3C0+A, 0x3C0+A+1 and so on, and each write carries byte k of `req_wdata` (bits 8k+7:8k).
- R2: A 2-byte legacy write appears as two byte writes in consecutive cycles. The low byte goes to 0x3C0+A first, then the high byte goes to 0x3C1+A.
- R3: A legacy read returns the byte read from port 0x3C0+A+k in bits 8k+7:8k of `rsp_rdata`. Bits above the access size read as zero.
- R4: A 4-byte legacy access is carried out as four ascending byte operations, which is two little-endian 2-byte pieces.
- R5: A mode access at offset A writes the index A>>1 (`mode_sel`=0, `mode_we`=1) and, in the next cycle, transfers the data port (`mode_sel`=1). A 4-byte access repeats this for the unit at index (A>>1)+1, carrying data bits 31:16.
- R6: A mode read returns unit u in bits 16u+15:16u. A 1-byte read returns only bits 7:0 of the data port. A 1-byte write sends the low byte zero-extended to 16 bits.
- R7: A 4-byte read at extended offset 0 returns 8, the size of the extended sub-window. A 4-byte read at offset 4 returns 0xBEBEBEBE when the byte-order flag is big-endian and 0x1E1E1E1E when it is little-endian.
- R8: A 4-byte write at extended offset 4 sets `fb_big_endian` only for 0xBEBEBEBE and clears it only for 0x1E1E1E1E. Any other value leaves the flag as it was.
- R9: An extended-window access that is not 4 bytes, or is not word aligned, reads all ones, and a write of that kind leaves the flag unchanged.
- R10: An access at an unmapped offset, with illegal size code 3, or running past the end of its sub-window, reads all ones and causes no legacy or mode port activity.
- R11: From acceptance until the response, `req_ready` is low. Each access yields exactly one single-cycle `rsp_valid` pulse, which comes after all of its port operations.
- R12: After reset `req_ready` is 1, `rsp_valid` is 0 and `fb_big_endian` is 0 (little-endian).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Bridge idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | 0:1 B, 1:2 B, 2:4 B, 3:illegal |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| leg_en | output | 1 | Legacy byte operation this cycle |
| leg_we | output | 1 | Legacy operation is a write |
| leg_port | output | 10 | Legacy port number |
| leg_wdata | output | 8 | Legacy write byte |
| leg_rdata | input | 8 | Legacy read byte, same cycle |
| mode_en | output | 1 | Mode port operation this cycle |
| mode_sel | output | 1 | 0 = index port, 1 = data port |
| mode_we | output | 1 | Mode operation is a write |
| mode_wdata | output | 16 | Mode index or data |
| mode_rdata | input | 16 | Mode data port, same cycle |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |

## Verification
The bench keeps a scoreboard of the exact port-operation stream for each access and the response that should follow it. It issues legacy accesses of 1, 2 and 4 bytes at different offsets, which separates a wrong byte order, a wrong port offset and a missing split. Mode accesses of 1, 2 and 4 bytes show whether the index comes before the data, whether the second unit's index is stepped and whether narrow reads are masked. Byte-order writes use both codes and a third value to check that the flag changes only on an exact match. Unmapped, oversize, straddling and misaligned accesses must give all ones, cause no port traffic and leave the flag unchanged.

// File: rtl/mmio_display_bridge.sv
module mmio_display_bridge #(
  parameter int AW         = 12,
  parameter int PW         = 10,
  parameter int LEG_BASE   = 'h400,
  parameter int LEG_SPAN   = 'h20,
  parameter int MODE_BASE  = 'h500,
  parameter int MODE_SPAN  = 'h18,
  parameter int EXT_BASE   = 'h600,
  parameter int EXT_SPAN   = 8,
  parameter logic [PW-1:0] PORT_BASE = 'h3C0,
  parameter logic [31:0] BE_CODE = 32'hBEBE_BEBE,
  parameter logic [31:0] LE_CODE = 32'h1E1E_1E1E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          leg_en,
  output logic          leg_we,
  output logic [PW-1:0] leg_port,
  output logic [7:0]    leg_wdata,
  input  logic [7:0]    leg_rdata,
  output logic          mode_en,
  output logic          mode_sel,
  output logic          mode_we,
  output logic [15:0]   mode_wdata,
  input  logic [15:0]   mode_rdata,
  output logic          fb_big_endian
);
  localparam logic [AW:0] LEG_LO  = (AW+1)'(LEG_BASE);
  localparam logic [AW:0] LEG_HI  = (AW+1)'(LEG_BASE + LEG_SPAN);
  localparam logic [AW:0] MODE_LO = (AW+1)'(MODE_BASE);
  localparam logic [AW:0] MODE_HI = (AW+1)'(MODE_BASE + MODE_SPAN);
  localparam logic [AW:0] EXT_LO  = (AW+1)'(EXT_BASE);
  localparam logic [AW:0] EXT_HI  = (AW+1)'(EXT_BASE + EXT_SPAN);

  typedef enum logic [1:0] {T_NONE, T_LEG, T_MODE, T_EXT} tgt_t;
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t           state;
  tgt_t          q_tgt, d_tgt;
  logic [2:0]    step, q_last, d_last;
  logic [AW-1:0] q_off, d_off;
  logic [1:0]    q_size;
  logic          q_we, be_q;
  logic [31:0]   q_wd, rd_q;

  logic [3:0]  nbytes;
  logic [AW:0] a_lo, a_hi;
  logic        size_ok;
  assign nbytes  = 4'd1 << req_size;
  assign size_ok = (req_size != 2'd3);
  assign a_lo    = {1'b0, req_addr};
  assign a_hi    = a_lo + (AW+1)'(nbytes);

  always_comb begin
    d_tgt  = T_NONE;
    d_off  = '0;
    d_last = 3'd0;
    if (size_ok && a_lo >= LEG_LO && a_hi <= LEG_HI) begin
      d_tgt  = T_LEG;
      d_off  = req_addr - AW'(LEG_BASE);
      d_last = 3'(nbytes - 4'd1);
    end else if (size_ok && a_lo >= MODE_LO && a_hi <= MODE_HI) begin
      d_tgt  = T_MODE;
      d_off  = req_addr - AW'(MODE_BASE);
      d_last = (req_size == 2'd2) ? 3'd3 : 3'd1;
    end else if (req_size == 2'd2 && req_addr[1:0] == 2'b00 &&
                 a_lo >= EXT_LO && a_hi <= EXT_HI) begin
      d_tgt  = T_EXT;
      d_off  = req_addr - AW'(EXT_BASE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      q_tgt  <= T_NONE;
      step   <= '0;
      q_last <= '0;
      q_off  <= '0;
      q_size <= '0;
      q_we   <= 1'b0;
      q_wd   <= '0;
      rd_q   <= '0;
      be_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state  <= S_BUSY;
          q_tgt  <= d_tgt;
          step   <= '0;
          q_last <= d_last;
          q_off  <= d_off;
          q_size <= req_size;
          q_we   <= req_write;
          q_wd   <= req_wdata;
          rd_q   <= (d_tgt == T_NONE) ? '1 : '0;
        end
        S_BUSY: begin
          case (q_tgt)
            T_LEG:  if (!q_we) rd_q[{step[1:0], 3'b000} +: 8] <= leg_rdata;
            T_MODE: if (!q_we && step[0]) rd_q[{step[1], 4'b0000} +: 16] <= mode_rdata;
            T_EXT: begin
              if (!q_we) begin
                if (q_off[2:0] == 3'd0)      rd_q <= 32'(EXT_SPAN);
                else if (q_off[2:0] == 3'd4) rd_q <= be_q ? BE_CODE : LE_CODE;
                else                         rd_q <= '1;
              end else if (q_off[2:0] == 3'd4) begin
                if (q_wd == BE_CODE)      be_q <= 1'b1;
                else if (q_wd == LE_CODE) be_q <= 1'b0;
              end
            end
            default: ;
          endcase
          if (step == q_last) state <= S_DONE;
          else                step  <= step + 3'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic busy;
  assign busy       = (state == S_BUSY);
  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_DONE);
  assign rsp_rdata  = (q_tgt == T_MODE && q_size == 2'd0) ? {24'h0, rd_q[7:0]} : rd_q;
  assign fb_big_endian = be_q;

  assign leg_en     = busy && (q_tgt == T_LEG);
  assign leg_we     = q_we;
  assign leg_port   = PORT_BASE + PW'(q_off) + PW'(step);
  assign leg_wdata  = q_wd[{step[1:0], 3'b000} +: 8];

  assign mode_en    = busy && (q_tgt == T_MODE);
  assign mode_sel   = step[0];
  assign mode_we    = !step[0] || q_we;
  assign mode_wdata = !step[0] ? 16'(q_off[AW-1:1]) + 16'(step[1]) :
                      (q_size == 2'd0) ? {8'h00, q_wd[7:0]} :
                      q_wd[{step[1], 4'b0000} +: 16];

  a_r2_leg_pair_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_en && step[0]) |-> ($past(leg_en) && leg_port == $past(leg_port) + PW'(1)));

  a_r5_index_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && mode_sel) |-> $past(mode_en && !mode_sel && mode_we));

  a_r8_flag_changes_on_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_big_endian) |-> $past(busy && q_tgt == T_EXT && q_we && q_off[2:0] == 3'd4));

  a_r11_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({leg_en, mode_en, rsp_valid}));
endmodule

// File: tb/mmio_display_bridge_bench.sv
module mmio_display_bridge_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, leg_en, leg_we, mode_en, mode_sel, mode_we, fb_big_endian;
  logic [31:0] rsp_rdata;
  logic [9:0] leg_port;
  logic [7:0] leg_wdata, leg_rdata;
  logic [15:0] mode_wdata, mode_rdata;

  mmio_display_bridge u_mmio_display_bridge (.*);

  logic [7:0]  lmem [32];
  logic [15:0] mregs [16];
  logic [15:0] m_idx;
  assign leg_rdata  = lmem[leg_port[4:0]];
  assign mode_rdata = mregs[m_idx[3:0]];
  always @(posedge clk) begin
    if (leg_en && leg_we) lmem[leg_port[4:0]] <= leg_wdata;
    if (mode_en && !mode_sel && mode_we) m_idx <= mode_wdata;
    if (mode_en && mode_sel && mode_we) mregs[m_idx[3:0]] <= mode_wdata;
  end

  int checks = 0, errors = 0;
  logic [47:0] expq [$];

  function automatic logic [47:0] ev(input logic [3:0] k, input logic [11:0] a, input logic [31:0] d);
    return {k, a, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [47:0] obs, e;
    logic have;
    have = 1;
    if (leg_en)          obs = ev(leg_we ? 4'd1 : 4'd2, {2'b0, leg_port}, {24'h0, leg_wdata});
    else if (mode_en)    obs = ev(!mode_sel ? 4'd3 : (mode_we ? 4'd4 : 4'd5), 12'h0, {16'h0, mode_wdata});
    else if (rsp_valid)  obs = ev(4'd0, 12'h0, rsp_rdata);
    else have = 0;
    if (have) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R10/R11 unexpected event actual %h expected none", obs);
      end else begin
        e = expq.pop_front();
        if (e[47:44] == 4'd6) begin
          if (obs[47:44] != 4'd0) begin errors++; $display("FAIL R11 actual %h expected write response", obs); end
        end else if (e[47:44] == 4'd7) begin
          if (obs !== ev(4'd0, 12'h0, e[31:0])) begin errors++; $display("FAIL R3/R6/R7/R9/R10 read actual %h expected %h", obs, e); end
        end else if (obs[47:44] != e[47:44] || obs[43:32] != e[43:32] ||
                     ((e[47:44] == 4'd1 || e[47:44] == 4'd3 || e[47:44] == 4'd4) && obs[31:0] != e[31:0])) begin
          errors++;
          $display("FAIL R1/R2/R4/R5 port op actual %h expected %h", obs, e);
        end
      end
    end
  end

  task automatic access(input logic we, input logic [11:0] addr, input logic [1:0] sz, input logic [31:0] wd);
    int n;
    logic [31:0] rd;
    logic [11:0] off;
    n = 1 << sz;
    rd = 0;
    if (sz != 3 && addr >= 12'h400 && int'(addr) + n <= 'h420) begin
      off = addr - 12'h400;
      for (int k = 0; k < n; k++) begin
        expq.push_back(ev(we ? 4'd1 : 4'd2, 12'h3C0 + off + 12'(k), {24'h0, wd[8*k +: 8]}));
        rd[8*k +: 8] = lmem[5'(off + 12'(k))];
      end
    end else if (sz != 3 && addr >= 12'h500 && int'(addr) + n <= 'h518) begin
      off = addr - 12'h500;
      for (int u = 0; u < (sz == 2 ? 2 : 1); u++) begin
        expq.push_back(ev(4'd3, 12'h0, 32'(off >> 1) + 32'(u)));
        expq.push_back(ev(we ? 4'd4 : 4'd5, 12'h0, sz == 0 ? {24'h0, wd[7:0]} : {16'h0, wd[16*u +: 16]}));
        rd[16*u +: 16] = mregs[4'((off >> 1) + 12'(u))];
      end
      if (sz == 0) rd = rd & 32'hFF;
    end else if (sz == 2 && addr[1:0] == 0 && addr >= 12'h600 && addr < 12'h608) begin
      rd = (addr == 12'h600) ? 32'd8 : 32'h0;
    end else rd = '1;
    expq.push_back(ev(we ? 4'd6 : 4'd7, 12'h0, rd));
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk("R11 ready low while busy", {31'h0, req_ready}, 32'h0);
    for (int t = 0; t < 20 && expq.size() != 0; t++) @(negedge clk);
    if (expq.size() != 0) begin
      chk("R11 access completed", expq.size(), 0);
      expq.delete();
    end
  endtask

  task automatic ext_read_bo(input string req, input logic big);
    logic [31:0] code;
    code = big ? 32'hBEBEBEBE : 32'h1E1E1E1E;
    expq.push_back(ev(4'd7, 12'h0, code));
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 12'h604; req_size = 2;
    @(negedge clk);
    req_valid = 0;
    for (int t = 0; t < 5 && expq.size() != 0; t++) @(negedge clk);
    chk(req, {31'h0, fb_big_endian}, {31'h0, big});
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) lmem[i] = 8'(i * 7 + 1);
    for (int i = 0; i < 16; i++) mregs[i] = 16'(i * 16'h1111 + 3);
    m_idx = 0;
    repeat (3) @(negedge clk);
    chk("R12 ready after reset", {31'h0, req_ready}, 1);
    chk("R12 no response after reset", {31'h0, rsp_valid}, 0);
    chk("R12 little-endian after reset", {31'h0, fb_big_endian}, 0);
    rst_n = 1;
    @(negedge clk);
    ext_read_bo("R7 R12 byte-order code at reset", 0);
    access(0, 12'h600, 2, 0);                 // R7 size word
    access(1, 12'h401, 0, 32'h5C);            // R1 single byte
    access(0, 12'h401, 0, 0);                 // R3 narrow read
    access(1, 12'h410, 1, 32'hA55A);          // R2 low byte first
    access(0, 12'h410, 1, 0);                 // R3
    access(1, 12'h404, 2, 32'hDEADBEEF);      // R4 split
    access(0, 12'h404, 2, 0);                 // R4 read
    access(0, 12'h41C, 2, 0);                 // R4 at end of window
    access(1, 12'h506, 1, 32'h1234);          // R5
    access(0, 12'h506, 1, 0);
    access(1, 12'h508, 2, 32'hCAFEF00D);      // R5 two units
    access(0, 12'h508, 2, 0);                 // R6
    access(1, 12'h50E, 0, 32'hFFFF77AB);      // R6 byte write zero-extended
    access(0, 12'h507, 0, 0);                 // R6 byte read masked
    access(1, 12'h604, 2, 32'hBEBEBEBE);
    ext_read_bo("R8 big-endian code sets flag", 1);
    access(1, 12'h604, 2, 32'h12345678);
    ext_read_bo("R8 other value keeps flag", 1);
    access(1, 12'h604, 1, 32'h1E1E1E1E);      // R9 wrong size ignored
    ext_read_bo("R9 narrow ext write ignored", 1);
    access(1, 12'h606, 2, 32'h1E1E1E1E);      // R9 misaligned ignored
    ext_read_bo("R9 misaligned ext write ignored", 1);
    access(0, 12'h604, 0, 0);                 // R9 narrow read ones
    access(1, 12'h604, 2, 32'h1E1E1E1E);
    ext_read_bo("R8 little-endian code clears flag", 0);
    access(0, 12'h000, 2, 0);                 // R10 unmapped
    access(1, 12'h700, 1, 32'h1111);          // R10 unmapped write
    access(0, 12'h400, 3, 0);                 // R10 illegal size
    access(1, 12'h41F, 1, 32'h7788);          // R10 straddles end
    access(0, 12'h41E, 1, 0);                 // R10 straddle write left legacy intact
    access(0, 12'h516, 2, 0);                 // R10 mode straddle
    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule